// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block decides which clock domains of a small system run and when the system moves between run mode and its three low-power modes: wait, doze and stop. The core asks for a low-power mode with a one-cycle request that carries a 2-bit mode code. The block then gates the clock enables of five domains: core, SRAM, watchdog, DMA and UART. Each domain's enable also depends on a software enable bit for that domain.

While the system is in a low-power mode, the block registers the interrupt and status lines of the peripherals and checks them against the current mode. The first wake source it accepts returns the system to run mode. Watchdog, DMA and UART interrupts can end wait or doze. Only a dedicated external wake line can end stop, because every clock is gated in stop. The DMA interrupt is formed inside the block from an interrupt-enable bit, a transfer-done flag and the error flags. Each return to run mode produces a one-cycle pulse with a code that names the source that caused it.

Top module: `lp_wake_ctrl`

## Requirements
- R1: Mode codes are 0 = RUN, 1 = WAIT, 2 = DOZE and 3 = STOP, and `mode_o` shows the current mode. After reset the mode is RUN. A `req_valid` pulse in RUN with a nonzero `req_mode` makes `mode_o` equal `req_mode` from the next cycle. A request with code 0, or any request made outside RUN, is ignored.
- R2: The enables use these bit positions: bit 0 core, bit 1 SRAM, bit 2 watchdog, bit 3 DMA, bit 4 UART. In WAIT, DOZE and STOP, `clk_en[1:0]` is low. It rises again in the same cycle that `mode_o` returns to RUN, with no recovery delay.
- R3: In STOP, all of `clk_en` is low. In WAIT and DOZE, `clk_en[4:2]` equals `periph_en[4:2]`. On leaving STOP, the UART enable returns with no reset of that domain, so the UART resumes from the state it had on entry.
- R4: In WAIT or DOZE, `wdt_irq` wakes the system only while both `wdt_en` and `periph_en[2]` are high.
- R5: The DMA interrupt is `dma_int_en` AND (`dma_done` OR any bit of `dma_err`). In WAIT or DOZE, with `periph_en[3]` high, this interrupt wakes the system.
- R6: In WAIT or DOZE, `uart_irq` wakes the system while `periph_en[4]` is high.
- R7: In STOP, the watchdog, DMA and UART interrupts have no effect. `ext_wake` ends any of the three low-power modes.
- R8: Every domain whose `periph_en` bit is low has its `clk_en` bit low in every mode, including after a wake.
- R9: Suppose an accepted wake source is high in cycle N while the block is in a low-power mode. Then `mode_o` is RUN in cycle N+2, and `wake_pulse` is high for that one cycle only. In that cycle `wake_src` holds 1 for watchdog, 2 for DMA, 3 for UART or 4 for external, and it holds 0 in every other cycle. When several sources are accepted together, the priority is external, then watchdog, then DMA, then UART.
- R10: If a source that the requested mode would accept is high in the cycle of the entry request, the entry is cancelled. The block stays in RUN and no wake pulse is produced.

Note on R10: a source that the requested mode ignores does not cancel the entry. For example, `uart_irq` does not prevent entry into STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle mode-entry request |
| req_mode | input | 2 | Requested mode code |
| periph_en | input | 5 | Software enable for each domain |
| wdt_en | input | 1 | Watchdog enable |
| wdt_irq | input | 1 | Watchdog interrupt |
| dma_int_en | input | 1 | DMA interrupt-enable control bit |
| dma_done | input | 1 | DMA transfer-done status |
| dma_err | input | 3 | DMA error status: configuration, source bus, destination bus |
| uart_irq | input | 1 | UART interrupt |
| ext_wake | input | 1 | Dedicated external wake |
| mode_o | output | 2 | Current mode |
| clk_en | output | 5 | Clock enable for each domain |
| wake_pulse | output | 1 | One-cycle pulse on return to RUN |
| wake_src | output | 3 | Code of the wake source |

## Verification
The bound checker tests the following on every cycle:
- clock gating against mode and software enables in every mode;
- the rule that RUN is left only through a request;
- wake pulses that last one cycle, occur only on a return to RUN, and are always tagged as external when leaving STOP.

Only the directed scenarios can show some behaviours:
- the two-cycle wake latency;
- the exact DMA interrupt formation;
- the effect of the watchdog enable;
- source priority;
- cancellation of an entry by a coincident wake, including the case where a UART interrupt does not block entry into STOP.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
   typedef enum logic [1:0] {
      LPW_RUN  = 2'd0,
      LPW_WAIT = 2'd1,
      LPW_DOZE = 2'd2,
      LPW_STOP = 2'd3
   } lpw_mode_e;

   // wake source indices; the reported code is index + 1
   localparam int SRC_WDT  = 0;
   localparam int SRC_DMA  = 1;
   localparam int SRC_UART = 2;
   localparam int SRC_EXT  = 3;
   localparam int NUM_SRC  = 4;

   // clock domain indices
   localparam int DOM_CORE = 0;
   localparam int DOM_SRAM = 1;
   localparam int DOM_WDT  = 2;
   localparam int DOM_DMA  = 3;
   localparam int DOM_UART = 4;
   localparam int NUM_DOM  = 5;
endpackage

// File: rtl/lpw_dma_qual.sv
module lpw_dma_qual #(
   parameter int NUM_ERR = 3
) (
   input  logic               int_en,
   input  logic               done,
   input  logic [NUM_ERR-1:0] err,
   output logic               irq
);
   logic any_err;

   generate
      if (NUM_ERR == 1) begin : g_single
         assign any_err = err[0];
      end else begin : g_multi
         assign any_err = |err;
      end
   endgenerate

   assign irq = int_en & (done | any_err);

   initial begin
      if (NUM_ERR < 1) $error("lpw_dma_qual: NUM_ERR must be at least 1");
   end
endmodule

// File: rtl/lpw_wake_sel.sv
module lpw_wake_sel
   import lpw_pkg::*;
#(
   parameter int                 N_SRC     = NUM_SRC,
   parameter int                 CODE_W    = 3,
   parameter logic [N_SRC-1:0]   LP_MASK   = '1,
   parameter logic [N_SRC-1:0]   STOP_MASK = '0
) (
   input  lpw_mode_e          mode,
   input  logic [N_SRC-1:0]   src,
   output logic               any,
   output logic [CODE_W-1:0]  code
);
   // lowest priority first; later entries override earlier ones
   localparam int PRIO_LO2HI [NUM_SRC] = '{SRC_UART, SRC_DMA, SRC_WDT, SRC_EXT};

   logic [N_SRC-1:0] allow;
   logic [N_SRC-1:0] hit;

   always_comb begin
      unique case (mode)
         LPW_WAIT, LPW_DOZE: allow = LP_MASK;
         LPW_STOP:           allow = STOP_MASK;
         default:            allow = '0;
      endcase
   end

   assign hit = src & allow;
   assign any = |hit;

   always_comb begin
      code = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (hit[PRIO_LO2HI[k]]) code = CODE_W'(PRIO_LO2HI[k] + 1);
      end
   end

   initial begin
      if (N_SRC != NUM_SRC) $error("lpw_wake_sel: N_SRC must match NUM_SRC");
      if ((1 << CODE_W) <= N_SRC) $error("lpw_wake_sel: CODE_W too narrow");
   end
endmodule

// File: rtl/lpw_clk_gate.sv
module lpw_clk_gate
   import lpw_pkg::*;
#(
   parameter int                 N_DOM   = NUM_DOM,
   parameter logic [N_DOM-1:0]   KEEP_LP = 5'b11100
) (
   input  lpw_mode_e         mode,
   input  logic [N_DOM-1:0]  sw_en,
   output logic [N_DOM-1:0]  en
);
   logic run_q;
   logic not_stop;

   assign run_q    = (mode == LPW_RUN);
   assign not_stop = (mode != LPW_STOP);

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      if (KEEP_LP[d]) begin : g_keep
         assign en[d] = sw_en[d] & not_stop;
      end else begin : g_runonly
         assign en[d] = sw_en[d] & run_q;
      end
   end
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
   import lpw_pkg::*;
#(
   parameter int                  NUM_DMA_ERR = 3,
   parameter int                  N_DOM       = NUM_DOM,
   parameter int                  SRC_CODE_W  = 3,
   parameter logic [N_DOM-1:0]    DOM_KEEP_LP = 5'b11100,
   parameter logic [NUM_SRC-1:0]  LP_WAKE    = 4'b1111,
   parameter logic [NUM_SRC-1:0]  STOP_WAKE  = 4'b1000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [1:0]              req_mode,
   input  logic [N_DOM-1:0]        periph_en,
   input  logic                    wdt_en,
   input  logic                    wdt_irq,
   input  logic                    dma_int_en,
   input  logic                    dma_done,
   input  logic [NUM_DMA_ERR-1:0]  dma_err,
   input  logic                    uart_irq,
   input  logic                    ext_wake,
   output logic [1:0]              mode_o,
   output logic [N_DOM-1:0]        clk_en,
   output logic                    wake_pulse,
   output logic [SRC_CODE_W-1:0]   wake_src
);
   lpw_mode_e               mode_q, mode_d;
   lpw_mode_e               req_m;
   logic [NUM_SRC-1:0]      raw_src;
   logic [NUM_SRC-1:0]      wake_q;
   logic                    dma_irq;
   logic                    acc_any;
   logic [SRC_CODE_W-1:0]   acc_code;
   logic                    cancel_any;
   logic [SRC_CODE_W-1:0]   cancel_code;
   logic                    in_lp;
   logic                    pulse_q;
   logic [SRC_CODE_W-1:0]   src_q;

   assign req_m = lpw_mode_e'(req_mode);
   assign in_lp = (mode_q != LPW_RUN);

   lpw_dma_qual #(.NUM_ERR(NUM_DMA_ERR)) u_dma (
      .int_en (dma_int_en),
      .done   (dma_done),
      .err    (dma_err),
      .irq    (dma_irq)
   );

   // a source counts only if its domain is enabled by software
   always_comb begin
      raw_src           = '0;
      raw_src[SRC_WDT]  = wdt_irq & wdt_en & periph_en[DOM_WDT];
      raw_src[SRC_DMA]  = dma_irq & periph_en[DOM_DMA];
      raw_src[SRC_UART] = uart_irq & periph_en[DOM_UART];
      raw_src[SRC_EXT]  = ext_wake;
   end

   // wake events are captured only while a low-power mode is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= '0;
      else        wake_q <= in_lp ? raw_src : '0;
   end

   lpw_wake_sel #(
      .N_SRC(NUM_SRC), .CODE_W(SRC_CODE_W),
      .LP_MASK(LP_WAKE), .STOP_MASK(STOP_WAKE)
   ) u_sel_lp (
      .mode (mode_q),
      .src  (wake_q),
      .any  (acc_any),
      .code (acc_code)
   );

   // same qualification against the requested mode decides cancellation
   lpw_wake_sel #(
      .N_SRC(NUM_SRC), .CODE_W(SRC_CODE_W),
      .LP_MASK(LP_WAKE), .STOP_MASK(STOP_WAKE)
   ) u_sel_cancel (
      .mode (req_m),
      .src  (raw_src),
      .any  (cancel_any),
      .code (cancel_code)
   );

   always_comb begin
      mode_d = mode_q;
      if (!in_lp) begin
         if (req_valid && (req_m != LPW_RUN) && !cancel_any) mode_d = req_m;
      end else if (acc_any) begin
         mode_d = LPW_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= LPW_RUN;
         pulse_q <= 1'b0;
         src_q   <= '0;
      end else begin
         mode_q  <= mode_d;
         pulse_q <= in_lp & acc_any;
         src_q   <= (in_lp & acc_any) ? acc_code : '0;
      end
   end

   lpw_clk_gate #(.N_DOM(N_DOM), .KEEP_LP(DOM_KEEP_LP)) u_gate (
      .mode  (mode_q),
      .sw_en (periph_en),
      .en    (clk_en)
   );

   assign mode_o     = mode_q;
   assign wake_pulse = pulse_q;
   assign wake_src   = src_q;

   logic unused_ok;
   assign unused_ok = ^cancel_code;

   initial begin
      if (N_DOM != NUM_DOM) $error("lp_wake_ctrl: N_DOM must equal NUM_DOM");
      if (NUM_DMA_ERR < 1) $error("lp_wake_ctrl: need at least one DMA error bit");
      if (SRC_CODE_W < 3) $error("lp_wake_ctrl: SRC_CODE_W must be at least 3");
      if (DOM_KEEP_LP[DOM_CORE] || DOM_KEEP_LP[DOM_SRAM])
         $error("lp_wake_ctrl: core and SRAM must be gated in low power");
      if (STOP_WAKE != (NUM_SRC'(1) << SRC_EXT))
         $error("lp_wake_ctrl: only the external source may end stop");
   end
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
   parameter int N_DOM  = 5,
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [N_DOM-1:0]  periph_en,
   input logic [1:0]        mode_o,
   input logic [N_DOM-1:0]  clk_en,
   input logic              wake_pulse,
   input logic [CODE_W-1:0] wake_src
);
   assert_run_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0 && !req_valid) |=> (mode_o == 2'd0));

   assert_core_sram_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd0) |-> (clk_en[1:0] == 2'b00));

   assert_core_sram_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0) |-> (clk_en[1:0] == periph_en[1:0]));

   assert_stop_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd3) |-> (clk_en == '0));

   assert_sw_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((clk_en & ~periph_en) == '0));

   assert_stop_ext_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pulse && $past(mode_o) == 2'd3) |-> (wake_src == CODE_W'(4)));

   assert_pulse_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (mode_o == 2'd0 && $past(mode_o) != 2'd0));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_src_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_pulse |-> (wake_src == '0));
endmodule

bind lp_wake_ctrl lpw_checker #(.N_DOM(N_DOM), .CODE_W(SRC_CODE_W)) u_lpw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .periph_en  (periph_en),
   .mode_o     (mode_o),
   .clk_en     (clk_en),
   .wake_pulse (wake_pulse),
   .wake_src   (wake_src)
);

// File: tb/tb_lp_wake_ctrl.sv
module tb_lp_wake_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = 2'd0;
   logic [4:0] periph_en = 5'b11111;
   logic       wdt_en = 1'b1;
   logic       wdt_irq = 1'b0;
   logic       dma_int_en = 1'b0;
   logic       dma_done = 1'b0;
   logic [2:0] dma_err = 3'b000;
   logic       uart_irq = 1'b0;
   logic       ext_wake = 1'b0;
   logic [1:0] mode_o;
   logic [4:0] clk_en;
   logic       wake_pulse;
   logic [2:0] wake_src;

   int n_checks = 0;
   int n_errors = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   lp_wake_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .periph_en(periph_en), .wdt_en(wdt_en), .wdt_irq(wdt_irq),
      .dma_int_en(dma_int_en), .dma_done(dma_done), .dma_err(dma_err),
      .uart_irq(uart_irq), .ext_wake(ext_wake), .mode_o(mode_o),
      .clk_en(clk_en), .wake_pulse(wake_pulse), .wake_src(wake_src)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_en(input logic [1:0] m, input logic [4:0] sw);
      if (m == 2'd0)      return sw;
      else if (m == 2'd3) return 5'b00000;
      else                return sw & 5'b11100;
   endfunction

   task automatic clear_src();
      wdt_irq = 0; dma_done = 0; dma_err = 0; dma_int_en = 0;
      uart_irq = 0; ext_wake = 0;
   endtask

   task automatic enter(input logic [1:0] m, input string req);
      @(negedge clk); req_valid = 1; req_mode = m;
      @(negedge clk); req_valid = 0; req_mode = 0;
      chk(req, mode_o, m);
      chk(req, clk_en, exp_en(m, periph_en));
   endtask

   // a source has already been set high at this negedge (cycle N)
   task automatic expect_wake(input int code, input string req);
      @(negedge clk); clear_src();
      chk(req, mode_o == 2'd0, 0);
      @(negedge clk);
      chk(req, mode_o, 0);
      chk(req, wake_pulse, 1);
      chk(req, wake_src, code);
      chk("R2", clk_en, exp_en(2'd0, periph_en));
      @(negedge clk);
      chk(req, wake_pulse, 0);
      chk(req, wake_src, 0);
   endtask

   task automatic expect_no_wake(input logic [1:0] m, input string req);
      repeat (3) begin
         @(negedge clk);
         chk(req, mode_o, m);
         chk(req, wake_pulse, 0);
      end
      clear_src();
   endtask

   task automatic t_reset();
      chk("R1", mode_o, 0);
      chk("R1", clk_en, 5'b11111);
      chk("R9", wake_pulse, 0);
   endtask

   task automatic t_ignored_requests();
      @(negedge clk); req_valid = 1; req_mode = 2'd0;
      @(negedge clk); req_valid = 0;
      chk("R1", mode_o, 0);
      enter(2'd1, "R1");
      @(negedge clk); req_valid = 1; req_mode = 2'd3;
      @(negedge clk); req_valid = 0; req_mode = 0;
      chk("R1", mode_o, 1);
      ext_wake = 1; expect_wake(4, "R7");
   endtask

   task automatic t_wdt();
      enter(2'd2, "R2");
      wdt_en = 0; wdt_irq = 1; expect_no_wake(2'd2, "R4");
      wdt_en = 1;
      @(negedge clk); wdt_irq = 1; expect_wake(1, "R4");
   endtask

   task automatic t_dma();
      enter(2'd1, "R5");
      dma_int_en = 0; dma_done = 1; expect_no_wake(2'd1, "R5");
      @(negedge clk); dma_int_en = 1; dma_err = 3'b010; expect_wake(2, "R5");
      enter(2'd2, "R5");
      @(negedge clk); dma_int_en = 1; dma_done = 1; expect_wake(2, "R5");
   endtask

   task automatic t_uart();
      enter(2'd1, "R6");
      @(negedge clk); uart_irq = 1; expect_wake(3, "R6");
   endtask

   task automatic t_stop();
      enter(2'd3, "R3");
      wdt_irq = 1; uart_irq = 1; dma_int_en = 1; dma_done = 1;
      expect_no_wake(2'd3, "R7");
      chk("R3", clk_en, 0);
      @(negedge clk); ext_wake = 1; expect_wake(4, "R7");
      chk("R3", clk_en[4], 1);
   endtask

   task automatic t_priority();
      enter(2'd2, "R9");
      @(negedge clk); wdt_irq = 1; uart_irq = 1; expect_wake(1, "R9");
      enter(2'd1, "R9");
      @(negedge clk); ext_wake = 1; dma_int_en = 1; dma_done = 1; expect_wake(4, "R9");
   endtask

   task automatic t_cancel();
      @(negedge clk); req_valid = 1; req_mode = 2'd1; uart_irq = 1;
      @(negedge clk); req_valid = 0; req_mode = 0;
      chk("R10", mode_o, 0);
      @(negedge clk);
      chk("R10", wake_pulse, 0);
      chk("R10", mode_o, 0);
      // UART is ignored in stop, so it cannot cancel a stop entry
      @(negedge clk); req_valid = 1; req_mode = 2'd3;
      @(negedge clk); req_valid = 0; req_mode = 0;
      chk("R10", mode_o, 3);
      uart_irq = 0;
      ext_wake = 1; expect_wake(4, "R10");
   endtask

   task automatic t_sw_disable();
      periph_en = 5'b01111;
      enter(2'd1, "R8");
      chk("R8", clk_en, 5'b01100);
      uart_irq = 1; expect_no_wake(2'd1, "R8");
      @(negedge clk); ext_wake = 1; expect_wake(4, "R8");
      chk("R8", clk_en, 5'b01111);
      periph_en = 5'b11111;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ignored_requests();
      t_wdt();
      t_dma();
      t_uart();
      t_stop();
      t_priority();
      t_cancel();
      t_sw_disable();
      done_flag = 1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule